// File: doc/BRIEF.md
# Line Signal Detect Qualifier

This block drives the active-low received-line-signal-detect output of a synchronous modem receiver. A periodic signed energy estimate is compared against two programmable levels: a turn-on level and a lower turn-off level. Energy at or above the turn-on level starts a qualification count of baud ticks. When the count reaches a delay set by the modulation family and train length, the detect output goes active. A training-complete pulse from the receiver skips the count and activates the output at once.

Once the detect output is active, energy below the turn-off level starts a hold timer counted in 0.1 ms ticks. The output drops only when that timer expires. If energy returns before expiry, the timer is cancelled. The two levels keep a minimum gap of 2 dB. A write that would break this gap is clamped.

Top module: `lsd_qualifier`

## Requirements
- R1: A one-cycle pulse on `train_done_i` makes `lsd_no` low at the next clock edge, whatever the state, and clears any running count.
- R2: With energy held at or above the turn-on level and no training pulse, `lsd_no` goes low on the 816th `baud_tick_i` counted, when `short_train_i`=0, for every family. The family codes on `family_i` are 0 = V.17/V.33, 1 = V.29 and 2 or 3 = V.27 ter.
- R3: With `short_train_i`=1 the qualification delay is 492 baud ticks for family 0 and 486 for family 2. Family 1 has no short train and keeps 816.
- R4: After `lsd_no` is low and energy falls below the turn-off level, `lsd_no` stays low until a mode-dependent number of `tick_100us_i` pulses have been counted, then goes high on that pulse. The counts are 400 for family 0, 350 for family 1 and 116 for family 2.
- R5: After reset the turn-on level reads -43 and the turn-off level reads -48 on `thr_on_o`/`thr_off_o`, and `lsd_no` is high.
- R6: The levels are compared in two's-complement dBm, sampled when `energy_valid_i`=1. Energy strictly between the two levels neither starts qualification from the inactive state nor starts the hold timer from the active state.
- R7: On `thr_wr_i`, the turn-on level is limited to no less than -126. The turn-off level is loaded as the lesser of `thr_off_i` and the turn-on level minus 2.
- R8: If energy rises to or above the turn-off level while the hold timer runs, the timer is cancelled and `lsd_no` stays low. A later drop restarts the full hold time.
- R9: If energy falls below the turn-on level during qualification, the baud count returns to zero. A later qualification needs the full count again.
- R10: `rst_ni` low forces `lsd_no` high at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| energy_valid_i | input | 1 | Energy sample strobe |
| energy_i | input | 8 | Signed energy estimate, dBm |
| train_done_i | input | 1 | Training sequence end pulse |
| baud_tick_i | input | 1 | One pulse per baud time |
| tick_100us_i | input | 1 | One pulse per 0.1 ms |
| family_i | input | 2 | Modulation family select |
| short_train_i | input | 1 | 1 = short train |
| thr_wr_i | input | 1 | Load both threshold levels |
| thr_on_i | input | 8 | New turn-on level, signed dBm |
| thr_off_i | input | 8 | New turn-off level, signed dBm |
| thr_on_o | output | 8 | Current turn-on level |
| thr_off_o | output | 8 | Current turn-off level |
| lsd_no | output | 1 | Line signal detect, active low |

## Verification
An energy sample updates the level flags at the edge where `energy_valid_i` is seen. The state machine reacts one edge later. The bench therefore waits three falling edges after each sample before it issues any tick. A tick pulse or a training pulse changes `lsd_no` at the same edge that samples it, so each check is made at the falling edge that follows. Each delay is checked on both sides of its boundary: one tick short of the count, where the output must not have changed, and on the final tick, where it must have.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_QUAL = 2'd1,
    ST_ON   = 2'd2,
    ST_HOLD = 2'd3
  } lsd_state_e;

  localparam logic [1:0] FAM_V17 = 2'd0;
  localparam logic [1:0] FAM_V29 = 2'd1;
endpackage

// File: rtl/lsd_thresh.sv
module lsd_thresh #(
  parameter int EW      = 8,
  parameter int ON_RST  = -43,
  parameter int OFF_RST = -48,
  parameter int HYST    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic signed [EW-1:0] on_i,
  input  logic signed [EW-1:0] off_i,
  output logic signed [EW-1:0] on_o,
  output logic signed [EW-1:0] off_o
);
  localparam logic signed [EW-1:0] ON_MIN = EW'(-(2 ** (EW-1)) + HYST);
  localparam logic signed [EW-1:0] HYST_V = EW'(HYST);

  logic signed [EW-1:0] on_lim, off_max, off_lim;

  always_comb begin
    on_lim  = (on_i < ON_MIN) ? ON_MIN : on_i;
    off_max = on_lim - HYST_V;
    off_lim = (off_i > off_max) ? off_max : off_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_o  <= EW'(ON_RST);
      off_o <= EW'(OFF_RST);
    end else if (wr_i) begin
      on_o  <= on_lim;
      off_o <= off_lim;
    end
  end

  // stored gap never shrinks below the hysteresis
  assert_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (EW+1)'(on_o) - (EW+1)'(off_o) >= (EW+1)'(HYST) || $signed(on_o) - $signed(off_o) >= HYST);
endmodule

// File: rtl/lsd_level.sv
module lsd_level #(
  parameter int EW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [EW-1:0] energy_i,
  input  logic signed [EW-1:0] on_i,
  input  logic signed [EW-1:0] off_i,
  output logic                 above_on_o,
  output logic                 below_off_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      above_on_o  <= 1'b0;
      below_off_o <= 1'b1;
    end else if (valid_i) begin
      above_on_o  <= (energy_i >= on_i);
      below_off_o <= (energy_i <  off_i);
    end
  end

  // with the gap kept, a sample can never be both
  assert_hyst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(above_on_o && below_off_o));
endmodule

// File: rtl/lsd_counter.sv
module lsd_counter #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/lsd_qualifier.sv
module lsd_qualifier
  import lsd_pkg::*;
#(
  parameter int EW          = 8,
  parameter int ON_RST      = -43,
  parameter int OFF_RST     = -48,
  parameter int HYST        = 2,
  parameter int BAUD_LONG   = 816,
  parameter int BAUD_V17_SH = 492,
  parameter int BAUD_V27_SH = 486,
  parameter int HOLD_V17    = 400,
  parameter int HOLD_V29    = 350,
  parameter int HOLD_V27    = 116
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 energy_valid_i,
  input  logic signed [EW-1:0] energy_i,
  input  logic                 train_done_i,
  input  logic                 baud_tick_i,
  input  logic                 tick_100us_i,
  input  logic [1:0]           family_i,
  input  logic                 short_train_i,
  input  logic                 thr_wr_i,
  input  logic signed [EW-1:0] thr_on_i,
  input  logic signed [EW-1:0] thr_off_i,
  output logic signed [EW-1:0] thr_on_o,
  output logic signed [EW-1:0] thr_off_o,
  output logic                 lsd_no
);
  localparam int BAUD_MAX = BAUD_LONG;
  localparam int HOLD_MAX = HOLD_V17 > HOLD_V29 ? HOLD_V17 : HOLD_V29;
  localparam int BCW = $clog2(BAUD_MAX + 1);
  localparam int HCW = $clog2(HOLD_MAX + 1);

  logic             above_on, below_off;
  logic [BCW-1:0]   baud_cnt, baud_tgt;
  logic [HCW-1:0]   hold_cnt, hold_tgt;
  logic             baud_clr, baud_inc, hold_clr, hold_inc;
  lsd_state_e       st_q, st_d;

  lsd_thresh #(.EW(EW), .ON_RST(ON_RST), .OFF_RST(OFF_RST), .HYST(HYST)) u_thresh (
    .clk_i, .rst_ni, .wr_i(thr_wr_i), .on_i(thr_on_i), .off_i(thr_off_i),
    .on_o(thr_on_o), .off_o(thr_off_o)
  );

  lsd_level #(.EW(EW)) u_level (
    .clk_i, .rst_ni, .valid_i(energy_valid_i), .energy_i,
    .on_i(thr_on_o), .off_i(thr_off_o),
    .above_on_o(above_on), .below_off_o(below_off)
  );

  lsd_counter #(.CW(BCW)) u_baud_cnt (
    .clk_i, .rst_ni, .clr_i(baud_clr), .inc_i(baud_inc), .cnt_o(baud_cnt)
  );

  lsd_counter #(.CW(HCW)) u_hold_cnt (
    .clk_i, .rst_ni, .clr_i(hold_clr), .inc_i(hold_inc), .cnt_o(hold_cnt)
  );

  // mode-dependent delays; family 1 has no short train, 2/3 are V.27 ter
  always_comb begin
    unique case (family_i)
      FAM_V17: begin
        baud_tgt = short_train_i ? BCW'(BAUD_V17_SH) : BCW'(BAUD_LONG);
        hold_tgt = HCW'(HOLD_V17);
      end
      FAM_V29: begin
        baud_tgt = BCW'(BAUD_LONG);
        hold_tgt = HCW'(HOLD_V29);
      end
      default: begin
        baud_tgt = short_train_i ? BCW'(BAUD_V27_SH) : BCW'(BAUD_LONG);
        hold_tgt = HCW'(HOLD_V27);
      end
    endcase
  end

  always_comb begin
    st_d     = st_q;
    baud_clr = 1'b0;
    baud_inc = 1'b0;
    hold_clr = 1'b0;
    hold_inc = 1'b0;
    if (train_done_i) begin
      st_d     = ST_ON;
      baud_clr = 1'b1;
      hold_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          baud_clr = 1'b1;
          hold_clr = 1'b1;
          if (above_on) st_d = ST_QUAL;
        end
        ST_QUAL: begin
          if (!above_on) begin
            st_d     = ST_OFF;
            baud_clr = 1'b1;
          end else if (baud_tick_i) begin
            if (baud_cnt >= baud_tgt - 1'b1) begin
              st_d     = ST_ON;
              baud_clr = 1'b1;
            end else begin
              baud_inc = 1'b1;
            end
          end
        end
        ST_ON: begin
          baud_clr = 1'b1;
          hold_clr = 1'b1;
          if (below_off) st_d = ST_HOLD;
        end
        ST_HOLD: begin
          if (!below_off) begin
            st_d     = ST_ON;
            hold_clr = 1'b1;
          end else if (tick_100us_i) begin
            if (hold_cnt >= hold_tgt - 1'b1) begin
              st_d     = ST_OFF;
              hold_clr = 1'b1;
            end else begin
              hold_inc = 1'b1;
            end
          end
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_d;
  end

  assign lsd_no = !(st_q == ST_ON || st_q == ST_HOLD);

  assert_train_on_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_done_i |=> !lsd_no);

  assert_qual_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_QUAL) |-> (baud_cnt < BCW'(BAUD_MAX)));

  assert_hold_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD) |-> (hold_cnt < HCW'(HOLD_MAX)));

  assert_hold_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && !below_off && !train_done_i) |=> (st_q == ST_ON && hold_cnt == '0));

  assert_qual_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_QUAL && !above_on && !train_done_i) |=> (baud_cnt == '0 && lsd_no));

  assert_off_only_after_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(lsd_no)) |-> ($past(st_q) == ST_HOLD));
endmodule

// File: tb/lsd_qualifier_tb.sv
module lsd_qualifier_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam int VEC_FAM  [NVEC] = '{0, 0, 1, 1, 2, 2};
  localparam int VEC_SH   [NVEC] = '{0, 1, 0, 1, 0, 1};
  localparam int VEC_BAUD [NVEC] = '{816, 492, 816, 816, 816, 486};
  localparam int VEC_HOLD [NVEC] = '{400, 400, 350, 350, 116, 116};

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              energy_valid_i = 1'b0;
  logic signed [7:0] energy_i = -8'sd80;
  logic              train_done_i = 1'b0;
  logic              baud_tick_i = 1'b0;
  logic              tick_100us_i = 1'b0;
  logic [1:0]        family_i = 2'd0;
  logic              short_train_i = 1'b0;
  logic              thr_wr_i = 1'b0;
  logic signed [7:0] thr_on_i = '0;
  logic signed [7:0] thr_off_i = '0;
  logic signed [7:0] thr_on_o, thr_off_o;
  logic              lsd_no;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lsd_qualifier u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i) rst_ni = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic set_energy(input int v);
    @(negedge clk_i);
    energy_i = 8'(v);
    energy_valid_i = 1'b1;
    @(negedge clk_i) energy_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic baud(input int n);
    for (int i = 0; i < n; i++) begin
      baud_tick_i = 1'b1;
      @(negedge clk_i) baud_tick_i = 1'b0;
      @(negedge clk_i);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_100us_i = 1'b1;
      @(negedge clk_i) tick_100us_i = 1'b0;
      @(negedge clk_i);
    end
  endtask

  task automatic train();
    train_done_i = 1'b1;
    @(negedge clk_i) train_done_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R5: reset state
    repeat (2) @(negedge clk_i);
    chk("R5 lsd_no in reset", lsd_no, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R5 thr_on default", thr_on_o, -43);
    chk("R5 thr_off default", thr_off_o, -48);
    chk("R5 lsd_no after reset", lsd_no, 1);

    // R2/R3/R4: mode table
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      family_i = 2'(VEC_FAM[v]);
      short_train_i = 1'(VEC_SH[v]);
      set_energy(-40);
      baud(VEC_BAUD[v] - 1);
      chk($sformatf("R2/R3 mode %0d one tick short", v), lsd_no, 1);
      baud(1);
      chk($sformatf("R2/R3 mode %0d on at count", v), lsd_no, 0);
      set_energy(-60);
      tick(VEC_HOLD[v] - 1);
      chk($sformatf("R4 mode %0d one tick short", v), lsd_no, 0);
      tick(1);
      chk($sformatf("R4 mode %0d off at expiry", v), lsd_no, 1);
    end

    // R1: training pulse shortcut, from off and from hold
    do_reset();
    family_i = 2'd0; short_train_i = 1'b0;
    train();
    chk("R1 train from off", lsd_no, 0);
    set_energy(-60);
    tick(399);
    train();
    tick(1);
    chk("R1 train in hold clears timer", lsd_no, 0);

    // R6: between levels, no qualify and no hold
    do_reset();
    set_energy(-45);
    baud(900);
    chk("R6 between levels no qualify", lsd_no, 1);
    train();
    set_energy(-45);
    tick(500);
    chk("R6 between levels no hold", lsd_no, 0);
    set_energy(-48);
    tick(400);
    chk("R6 at off level no hold", lsd_no, 0);

    // R8: hold abort and full restart
    set_energy(-60);
    tick(300);
    set_energy(-47);
    tick(200);
    chk("R8 hold cancelled", lsd_no, 0);
    set_energy(-60);
    tick(399);
    chk("R8 full hold restarted", lsd_no, 0);
    tick(1);
    chk("R8 off after restarted hold", lsd_no, 1);

    // R9: qualification count cleared on drop
    do_reset();
    family_i = 2'd2; short_train_i = 1'b1;
    set_energy(-43);
    baud(400);
    set_energy(-44);
    set_energy(-43);
    baud(485);
    chk("R9 count restarted", lsd_no, 1);
    baud(1);
    chk("R9 on after full count", lsd_no, 0);

    // R7: clamp and programmability
    do_reset();
    @(negedge clk_i);
    thr_on_i = -8'sd30; thr_off_i = -8'sd29; thr_wr_i = 1'b1;
    @(negedge clk_i) thr_wr_i = 1'b0;
    chk("R7 on loaded", thr_on_o, -30);
    chk("R7 off clamped", thr_off_o, -32);
    thr_on_i = -8'sd128; thr_off_i = -8'sd100; thr_wr_i = 1'b1;
    @(negedge clk_i) thr_wr_i = 1'b0;
    chk("R7 on floor", thr_on_o, -126);
    chk("R7 off floor", thr_off_o, -128);
    thr_on_i = -8'sd20; thr_off_i = -8'sd50; thr_wr_i = 1'b1;
    @(negedge clk_i) thr_wr_i = 1'b0;
    chk("R7 off kept", thr_off_o, -50);
    family_i = 2'd0; short_train_i = 1'b1;
    set_energy(-30);
    baud(492);
    chk("R6 below new on level", lsd_no, 1);
    set_energy(-20);
    baud(492);
    chk("R6 at new on level", lsd_no, 0);

    // R10: async reset
    #(CLK_PERIOD/4) rst_ni = 1'b0;
    #1 chk("R10 async reset forces high", lsd_no, 1);
    @(negedge clk_i) rst_ni = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule